// File: doc/BRIEF.md
# Segmented Dual-Clock DMA RAM

This block is a simple dual-port memory placed between a DMA engine and its clients. One side can only write and the other side can only read. Each side runs on its own clock and has its own reset, so the engine and a client may sit in unrelated clock domains and need no FIFO between them.

Both sides are split into `SEGS` lanes of `SEG_DW` bits. Each lane has its own address, data and handshake, and each lane owns its own bank of rows. All lanes can therefore move a word in the same cycle, with no arbitration between them. The full interface is `SEGS*SEG_DW` bits wide, and a word is located by its lane index and its row. The number of rows per lane is set by `DEPTH`, which is independent of the address width `ADDR_W`.

On the read side, `PIPE` extra register stages can be added after the array read to help timing. Every command moves exactly one word. There are no bursts, no address decoding and no reordering.

Top module: `seg_dc_ram`

## Requirements
- R1: A word written on the write clock can afterwards be read back unchanged on the read clock, in the same lane and row.
- R2: Each lane stores its rows apart from every other lane. All lanes may be written, and read, in the same cycle. Out of reset, `wr_cmd_ready` is high on every lane.
- R3: Bit b of a lane's byte-enable field covers data bits 8b+7 down to 8b of that lane. Bytes whose enable is low keep their earlier value.
- R4: The row is taken from the low clog2(`DEPTH`) bits of a lane's address. Address bits above those are ignored, so addresses that differ only there reach the same row.
- R5: `wr_done` of a lane goes high for exactly one write-clock cycle. That cycle follows the edge at which the write was accepted.
- R6: With `rd_resp_ready` held high, a read accepted at one read-clock edge shows `rd_resp_valid` after edge number `PIPE`+1, counting the accepting edge as the first. It does not show earlier.
- R7: While a lane has `rd_resp_valid` high and `rd_resp_ready` low, that lane's response data and valid stay unchanged and `rd_cmd_ready` stays low.
- R8: Within a lane, responses leave in the same order as their read commands were accepted, including across a stall.
- R9: While its reset is high, each side drives its outputs as follows: `wr_cmd_ready` and `wr_done` are low on the write side, and `rd_resp_valid` is low on the read side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Write-side synchronous reset, active high |
| wr_cmd_be | input | SEGS*SEG_DW/8 | Byte enables, one field per lane |
| wr_cmd_addr | input | SEGS*ADDR_W | Write address, one field per lane |
| wr_cmd_data | input | SEGS*SEG_DW | Write data, one field per lane |
| wr_cmd_valid | input | SEGS | Write command valid per lane |
| wr_cmd_ready | output | SEGS | Write command ready per lane |
| wr_done | output | SEGS | One-cycle write completion pulse per lane |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Read-side synchronous reset, active high |
| rd_cmd_addr | input | SEGS*ADDR_W | Read address, one field per lane |
| rd_cmd_valid | input | SEGS | Read command valid per lane |
| rd_cmd_ready | output | SEGS | Read command ready per lane |
| rd_resp_data | output | SEGS*SEG_DW | Read response data, one field per lane |
| rd_resp_valid | output | SEGS | Read response valid per lane |
| rd_resp_ready | input | SEGS | Read response accepted per lane |

## Verification
The hardest state to reach from the ports is a full read pipeline held by back-pressure. In that state one response waits at the output while a second is still in flight behind it. The stimulus drops `rd_resp_ready` and then issues two reads on back-to-back read-clock edges, so the first reaches the output stage while the second is one stage behind. It then holds the stall for several cycles before releasing it. During the stall the test checks that the waiting word and the blocked command ready do not change, and after release it checks that the second word follows the first. Byte-enable merging and ignored upper address bits are reached by rewriting the same row through aliased addresses with partial enables, and then reading the merged word.

// File: rtl/seg_dc_ram.sv
module seg_dc_ram #(
  parameter int SEGS   = 2,
  parameter int SEG_DW = 32,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 16,
  parameter int PIPE   = 2
) (
  input  logic                         wr_clk,
  input  logic                         wr_rst,
  input  logic [SEGS*(SEG_DW/8)-1:0]   wr_cmd_be,
  input  logic [SEGS*ADDR_W-1:0]       wr_cmd_addr,
  input  logic [SEGS*SEG_DW-1:0]       wr_cmd_data,
  input  logic [SEGS-1:0]              wr_cmd_valid,
  output logic [SEGS-1:0]              wr_cmd_ready,
  output logic [SEGS-1:0]              wr_done,
  input  logic                         rd_clk,
  input  logic                         rd_rst,
  input  logic [SEGS*ADDR_W-1:0]       rd_cmd_addr,
  input  logic [SEGS-1:0]              rd_cmd_valid,
  output logic [SEGS-1:0]              rd_cmd_ready,
  output logic [SEGS*SEG_DW-1:0]       rd_resp_data,
  output logic [SEGS-1:0]              rd_resp_valid,
  input  logic [SEGS-1:0]              rd_resp_ready
);

  localparam int BE_W  = SEG_DW / 8;
  localparam int ROW_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int STG   = PIPE + 1;

  assign wr_cmd_ready = {SEGS{~wr_rst}};

  for (genvar s = 0; s < SEGS; s++) begin : g_lane
    logic [SEG_DW-1:0] bank [DEPTH];
    logic [ROW_W-1:0]  wrow, rrow;
    logic [BE_W-1:0]   be;
    logic              wfire, done_q;
    logic [SEG_DW-1:0] stg_d [STG];
    logic [STG-1:0]    stg_v;
    logic              adv, rfire;

    assign wrow  = wr_cmd_addr[s*ADDR_W +: ROW_W];
    assign rrow  = rd_cmd_addr[s*ADDR_W +: ROW_W];
    assign be    = wr_cmd_be[s*BE_W +: BE_W];
    assign wfire = wr_cmd_valid[s] & wr_cmd_ready[s];

    always_ff @(posedge wr_clk) begin
      if (wfire)
        for (int b = 0; b < BE_W; b++)
          if (be[b]) bank[wrow][b*8 +: 8] <= wr_cmd_data[s*SEG_DW + b*8 +: 8];
    end

    always_ff @(posedge wr_clk) begin
      if (wr_rst) done_q <= 1'b0;
      else        done_q <= wfire;
    end
    assign wr_done[s] = done_q;

    assign adv             = ~stg_v[STG-1] | rd_resp_ready[s];
    assign rd_cmd_ready[s] = adv & ~rd_rst;
    assign rfire           = rd_cmd_valid[s] & rd_cmd_ready[s];

    always_ff @(posedge rd_clk) begin
      if (rd_rst) stg_v <= '0;
      else if (adv) begin
        stg_v[0] <= rfire;
        for (int k = 1; k < STG; k++) stg_v[k] <= stg_v[k-1];
      end
    end

    always_ff @(posedge rd_clk) begin
      if (adv) begin
        stg_d[0] <= bank[rrow];
        for (int k = 1; k < STG; k++) stg_d[k] <= stg_d[k-1];
      end
    end

    assign rd_resp_data[s*SEG_DW +: SEG_DW] = stg_d[STG-1];
    assign rd_resp_valid[s]                 = stg_v[STG-1];
  end

endmodule

// File: rtl/seg_dc_ram_chk.sv
module seg_dc_ram_chk #(
  parameter int SEGS   = 2,
  parameter int SEG_DW = 32
) (
  input logic                   wr_clk,
  input logic                   wr_rst,
  input logic [SEGS-1:0]        wr_cmd_valid,
  input logic [SEGS-1:0]        wr_cmd_ready,
  input logic [SEGS-1:0]        wr_done,
  input logic                   rd_clk,
  input logic                   rd_rst,
  input logic [SEGS-1:0]        rd_cmd_ready,
  input logic [SEGS*SEG_DW-1:0] rd_resp_data,
  input logic [SEGS-1:0]        rd_resp_valid,
  input logic [SEGS-1:0]        rd_resp_ready
);

  for (genvar s = 0; s < SEGS; s++) begin : g_chk
    a_r5_done_follows: assert property (@(posedge wr_clk) disable iff (wr_rst)
      (wr_cmd_valid[s] && wr_cmd_ready[s]) |=> wr_done[s]);

    a_r5_done_needs_write: assert property (@(posedge wr_clk) disable iff (wr_rst)
      wr_done[s] |-> $past(wr_cmd_valid[s] && wr_cmd_ready[s]));

    a_r7_hold_resp: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (rd_resp_valid[s] && !rd_resp_ready[s]) |=>
        (rd_resp_valid[s] && $stable(rd_resp_data[s*SEG_DW +: SEG_DW])));

    a_r7_block_cmd: assert property (@(posedge rd_clk) disable iff (rd_rst)
      (rd_resp_valid[s] && !rd_resp_ready[s]) |-> !rd_cmd_ready[s]);
  end

endmodule

bind seg_dc_ram seg_dc_ram_chk #(.SEGS(SEGS), .SEG_DW(SEG_DW)) u_chk (
  .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_cmd_valid(wr_cmd_valid),
  .wr_cmd_ready(wr_cmd_ready), .wr_done(wr_done),
  .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_cmd_ready(rd_cmd_ready),
  .rd_resp_data(rd_resp_data), .rd_resp_valid(rd_resp_valid),
  .rd_resp_ready(rd_resp_ready)
);

// File: tb/seg_dc_ram_test.sv
`timescale 1ns/1ps
module seg_dc_ram_test;
  localparam int SEGS = 2, DW = 32, AW = 8;

  logic wr_clk = 0, rd_clk = 0, wr_rst = 1, rd_rst = 1;
  logic [SEGS*4-1:0]  wr_cmd_be = '0;
  logic [SEGS*AW-1:0] wr_cmd_addr = '0, rd_cmd_addr = '0;
  logic [SEGS*DW-1:0] wr_cmd_data = '0, rd_resp_data;
  logic [SEGS-1:0] wr_cmd_valid = '0, wr_cmd_ready, wr_done;
  logic [SEGS-1:0] rd_cmd_valid = '0, rd_cmd_ready, rd_resp_valid, rd_resp_ready = '1;

  always #2 wr_clk = ~wr_clk;
  always #3 rd_clk = ~rd_clk;

  seg_dc_ram #(.SEGS(SEGS), .SEG_DW(DW), .ADDR_W(AW), .DEPTH(16), .PIPE(2)) uut (.*);

  int n_run = 0, n_fail = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int s, logic [7:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge wr_clk);
    wr_cmd_valid[s] = 1'b1;
    wr_cmd_addr[s*AW +: AW] = a;
    wr_cmd_be[s*4 +: 4] = be;
    wr_cmd_data[s*DW +: DW] = d;
    @(negedge wr_clk);
    wr_cmd_valid = '0;
    chk("R5 done pulse", 32'(wr_done[s]), 32'd1);
    @(negedge wr_clk);
    chk("R5 single cycle", 32'(wr_done[s]), 32'd0);
  endtask

  task automatic rd(int s, logic [7:0] a, output logic [31:0] q);
    @(negedge rd_clk);
    rd_cmd_valid[s] = 1'b1;
    rd_cmd_addr[s*AW +: AW] = a;
    @(negedge rd_clk);
    rd_cmd_valid = '0;
    @(negedge rd_clk);
    chk("R6 not early", 32'(rd_resp_valid[s]), 32'd0);
    @(negedge rd_clk);
    chk("R6 latency", 32'(rd_resp_valid[s]), 32'd1);
    q = rd_resp_data[s*DW +: DW];
    @(negedge rd_clk);
  endtask

  typedef struct packed {
    logic        seg;
    logic [7:0]  wa;
    logic [3:0]  be;
    logic [31:0] wd;
    logic [7:0]  ra;
    logic [31:0] ex;
  } vec_t;

  // R1 R3 R4 vectors: write, then read back the merged word
  localparam vec_t VEC [7] = '{
    '{1'b0, 8'h03, 4'hF, 32'h11223344, 8'h03, 32'h11223344},
    '{1'b0, 8'h03, 4'h1, 32'hAAAAAAAA, 8'h03, 32'h112233AA},
    '{1'b0, 8'h03, 4'hC, 32'h55667788, 8'h03, 32'h556633AA},
    '{1'b1, 8'h03, 4'hF, 32'hDEADBEEF, 8'h03, 32'hDEADBEEF},
    '{1'b1, 8'h13, 4'h2, 32'h00005A00, 8'h03, 32'hDEAD5AEF},
    '{1'b0, 8'h0F, 4'hF, 32'hCAFEF00D, 8'h2F, 32'hCAFEF00D},
    '{1'b1, 8'h00, 4'hF, 32'h01020304, 8'hF0, 32'h01020304}
  };

  logic [31:0] q;

  initial begin
    repeat (3) @(negedge wr_clk);
    chk("R9 wr ready in reset", 32'(wr_cmd_ready), 32'd0);
    chk("R9 done in reset", 32'(wr_done), 32'd0);
    chk("R9 resp valid in reset", 32'(rd_resp_valid), 32'd0);
    @(negedge wr_clk); wr_rst = 0;
    @(negedge rd_clk); rd_rst = 0;
    @(negedge wr_clk);
    chk("R2 ready out of reset", 32'(wr_cmd_ready), 32'h3);

    for (int i = 0; i < 7; i++) begin
      wr(VEC[i].seg, VEC[i].wa, VEC[i].be, VEC[i].wd);
      rd(VEC[i].seg, VEC[i].ra, q);
      chk($sformatf("R1 R3 R4 vector %0d", i), q, VEC[i].ex);
    end

    // R2: lane 0 untouched by lane 1 writes to the same row
    rd(0, 8'h03, q);
    chk("R2 lane isolation", q, 32'h556633AA);

    // R2: both lanes written and read in the same cycle
    @(negedge wr_clk);
    wr_cmd_valid = 2'b11; wr_cmd_be = 8'hFF;
    wr_cmd_addr = {8'h07, 8'h07};
    wr_cmd_data = {32'h17171717, 32'h70707070};
    @(negedge wr_clk);
    wr_cmd_valid = '0;
    chk("R2 both done", 32'(wr_done), 32'h3);
    @(negedge rd_clk);
    rd_cmd_valid = 2'b11; rd_cmd_addr = {8'h07, 8'h07};
    @(negedge rd_clk); rd_cmd_valid = '0;
    @(negedge rd_clk);
    @(negedge rd_clk);
    chk("R2 both valid", 32'(rd_resp_valid), 32'h3);
    chk("R2 lane0 data", rd_resp_data[31:0], 32'h70707070);
    chk("R2 lane1 data", rd_resp_data[63:32], 32'h17171717);
    @(negedge rd_clk);

    // R7 R8: stall with two reads in flight on lane 0
    rd_resp_ready[0] = 1'b0;
    rd_cmd_valid[0] = 1'b1; rd_cmd_addr[7:0] = 8'h03;
    @(negedge rd_clk); rd_cmd_addr[7:0] = 8'h0F;
    @(negedge rd_clk); rd_cmd_valid = '0;
    @(negedge rd_clk);
    chk("R7 stalled valid", 32'(rd_resp_valid[0]), 32'd1);
    chk("R8 first word", rd_resp_data[31:0], 32'h556633AA);
    chk("R7 cmd blocked", 32'(rd_cmd_ready[0]), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge rd_clk);
      chk("R7 hold data", rd_resp_data[31:0], 32'h556633AA);
    end
    rd_resp_ready[0] = 1'b1;
    @(negedge rd_clk);
    chk("R8 second valid", 32'(rd_resp_valid[0]), 32'd1);
    chk("R8 second word", rd_resp_data[31:0], 32'hCAFEF00D);
    @(negedge rd_clk);
    chk("R8 drained", 32'(rd_resp_valid[0]), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge wr_clk);
    n_run++; n_fail++;
    $display("FAIL R1 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule